// File: doc/BRIEF.md
# Serial Receive Path with Per-Character Error Status

This block receives asynchronous serial characters and places them in a receive queue. It samples the line at sixteen times the bit rate and builds 8-bit characters, sent least significant bit first. Parity can be enabled and set to odd or even. Each queued character carries its own parity-error and framing-error marks. The status register shows the marks of the character at the head of the queue only. An overrun mark is raised when a character arrives and there is no room for it. Reading the status register clears the error marks.

Software uses a small register port to configure the block, pop characters and read status. An interrupt line combines two sources: "enough data waiting", judged against a selectable fill threshold, and "a line error is present". A loopback control routes the transmitter's shift output into the receiver. In loopback the external serial input is ignored and the external serial output is held high.

Top module: `uart_rx_status`

## Requirements
- R1: The line is sampled on each `sampleTick`, sixteen samples per bit. A low level starts a frame only if it is still low at the mid-bit sample eight ticks later. A shorter low pulse produces no character. Data bits are taken at mid-bit, least significant bit first.
- R2: Control bit 3 enables a parity bit after the data. Control bit 4 selects odd parity when set and even parity when clear. A parity mismatch marks the character with a parity error. With parity disabled, no parity error is ever marked.
- R3: A low level at the mid-bit sample of the first stop bit marks the character with a framing error. The character is still stored.
- R4: After a framing error, the low stop sample is taken as the start bit of the next character. The following eight bit periods are received as that character with no new start-bit search. For example, a line held high after a low stop bit yields an extra 0xFF character.
- R5: Status bit 2 (parity) and bit 3 (framing) show the marks of the character at the head of the queue. They reload whenever a different character becomes the head, and read zero when the queue is empty. Status bit 0 is set while the queue holds a character.
- R6: A read at address 2 returns the status and clears bits 1 to 3. The ready bit (bit 0) is not changed by this read. A read at address 0 returns the head character and removes it from the queue.
- R7: With control bit 0 set, the queue holds 16 characters. A character that completes while 16 are held is discarded and sets overrun (status bit 1). The threshold setting has no effect on this. The stored characters stay unchanged and in order.
- R8: Overrun stays set until a status read. While overrun, parity or framing is set and control bit 7 is set, `irq` is high in that same cycle.
- R9: With control bit 0 clear, the block holds one character. A second character that completes before the first is read is discarded and sets overrun. The first character is kept.
- R10: With control bit 6 set, `irq` is high while the held count reaches the threshold. Control bits 2:1 select the threshold: 0 gives 1 character, 1 gives 4, 2 gives 8 and 3 gives 14. With the queue disabled, the threshold is 1 character.
- R11: Control bit 5 selects loopback. In loopback, `serialOut` is 1, `serialIn` is ignored and `txShiftOut` feeds the receiver. Otherwise `serialOut` follows `txShiftOut`.
- R12: After reset, the control register reads 0, the status register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One pulse per sixteenth of a bit |
| serialIn | input | 1 | External serial receive line |
| txShiftOut | input | 1 | Transmitter shift-register output |
| serialOut | output | 1 | External serial transmit line |
| regAddr | input | 2 | Register select: 0 data, 1 control, 2 status |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; qualifies read side effects |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full 16-entry queue with one more character already in the shift register. The stimulus streams seventeen complete frames with no reads in between. It then checks that the interrupt rose before any read, pops all sixteen stored values in order, and only then reads the status to see overrun clear. The framing resynchronization needs a low stop bit followed by a line that stays high. This produces a second character that no start edge began. The bench expects that extra 0xFF and checks that its error marks come up clean once it reaches the head.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;

  // Control register image, bit 0 is the LSB
  typedef struct packed {
    logic       lsIrqEn;    // bit 7
    logic       rxIrqEn;    // bit 6
    logic       loopback;   // bit 5
    logic       parityOdd;  // bit 4
    logic       parityEn;   // bit 3
    logic [1:0] trigSel;    // bits 2:1
    logic       fifoEn;     // bit 0
  } rxCfg_t;

  // Strobes from the bit-level control to the datapath
  typedef struct packed {
    logic              charDone;
    logic [DATA_W-1:0] data;
    logic              parityErr;
    logic              frameErr;
  } rxStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              pe;
    logic              fe;
  } rxEntry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      serialIn,
  input  logic      txShiftOut,
  input  logic      loopback,
  input  logic      parityEn,
  input  logic      parityOdd,
  output rxStrobe_t stb
);

  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(DATA_W);

  logic [1:0]        syncQ;
  logic              lineBit;
  rxState_t          state;
  logic [CW-1:0]     tickCnt;
  logic [BW-1:0]     bitIdx;
  logic [DATA_W-1:0] shiftQ;
  logic              parBit;
  logic              atHalf, atFull, expPar;

  assign lineBit = syncQ[1];
  assign atHalf  = tickCnt == CW'(HALF - 1);
  assign atFull  = tickCnt == CW'(OSR - 1);
  assign expPar  = parityOdd ? ~^shiftQ : ^shiftQ;

  // Input selection ahead of a two-stage synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], loopback ? txShiftOut : serialIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      shiftQ  <= '0;
      parBit  <= 1'b0;
      stb     <= '0;
    end else begin
      stb.charDone <= 1'b0;
      if (sampleTick) begin
        case (state)
          ST_IDLE: begin
            if (!lineBit) begin
              state   <= ST_START;
              tickCnt <= '0;
            end
          end
          ST_START: begin
            if (atHalf) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= lineBit ? ST_IDLE : ST_DATA;
            end else tickCnt <= tickCnt + 1'b1;
          end
          ST_DATA: begin
            if (atFull) begin
              tickCnt <= '0;
              shiftQ  <= {lineBit, shiftQ[DATA_W-1:1]};
              bitIdx  <= bitIdx + 1'b1;
              if (bitIdx == BW'(DATA_W - 1))
                state <= parityEn ? ST_PARITY : ST_STOP;
            end else tickCnt <= tickCnt + 1'b1;
          end
          ST_PARITY: begin
            if (atFull) begin
              tickCnt <= '0;
              parBit  <= lineBit;
              state   <= ST_STOP;
            end else tickCnt <= tickCnt + 1'b1;
          end
          ST_STOP: begin
            if (atFull) begin
              tickCnt       <= '0;
              bitIdx        <= '0;
              stb.charDone  <= 1'b1;
              stb.data      <= shiftQ;
              stb.parityErr <= parityEn && (parBit != expPar);
              stb.frameErr  <= !lineBit;
              // a low stop sample is taken as the next start bit
              state         <= lineBit ? ST_IDLE : ST_DATA;
            end else tickCnt <= tickCnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output rxCfg_t            cfg,
  output logic [3:0]        lineStat,
  output logic              dataAvail
);

  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;

  rxEntry_t       mem [DEPTH];
  logic [AW-1:0]  wrPtr, rdPtr, nxtPtr;
  logic [CNTW-1:0] count, capacity, trigLevel;
  logic           full, push, pop, overrunNow;
  logic           dataRead, lsrRead, ctrlWrite;
  logic           headLoad;
  logic [1:0]     headNext;
  logic           oeQ, peQ, feQ;

  assign dataRead   = regRdEn && regAddr == ADDR_DATA;
  assign lsrRead    = regRdEn && regAddr == ADDR_STAT;
  assign ctrlWrite  = regWrEn && regAddr == ADDR_CTRL;
  assign capacity   = cfg.fifoEn ? CNTW'(DEPTH) : CNTW'(1);
  assign full       = count >= capacity;
  assign push       = stb.charDone && !full;
  assign overrunNow = stb.charDone && full;
  assign pop        = dataRead && count != '0;
  assign nxtPtr     = rdPtr + AW'(1);

  always_comb begin
    case (cfg.trigSel)
      2'd0:    trigLevel = CNTW'(1);
      2'd1:    trigLevel = CNTW'(4);
      2'd2:    trigLevel = CNTW'(8);
      default: trigLevel = CNTW'(14);
    endcase
  end

  // Marks of whichever character becomes the new head
  always_comb begin
    headLoad = 1'b0;
    headNext = 2'b00;
    if (pop) begin
      headLoad = 1'b1;
      if (count > CNTW'(1))  headNext = {mem[nxtPtr].pe, mem[nxtPtr].fe};
      else if (push)         headNext = {stb.parityErr, stb.frameErr};
    end else if (push && count == '0) begin
      headLoad = 1'b1;
      headNext = {stb.parityErr, stb.frameErr};
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {stb.data, stb.parityErr, stb.frameErr};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      cfg   <= '0;
      oeQ   <= 1'b0;
      peQ   <= 1'b0;
      feQ   <= 1'b0;
    end else begin
      if (push) wrPtr <= wrPtr + AW'(1);
      if (pop)  rdPtr <= nxtPtr;
      count <= count + CNTW'(push) - CNTW'(pop);
      if (ctrlWrite) cfg <= rxCfg_t'(regWrData);
      if (headLoad)     {peQ, feQ} <= headNext;
      else if (lsrRead) {peQ, feQ} <= 2'b00;
      if (overrunNow)   oeQ <= 1'b1;
      else if (lsrRead) oeQ <= 1'b0;
    end
  end

  assign lineStat  = {feQ, peQ, oeQ, count != '0};
  assign dataAvail = cfg.fifoEn ? (count >= trigLevel) : (count != '0);

  always_comb begin
    case (regAddr)
      ADDR_DATA: regRdData = (count != '0) ? mem[rdPtr].data : '0;
      ADDR_CTRL: regRdData = cfg;
      ADDR_STAT: regRdData = {4'b0000, lineStat};
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       serialIn,
  input  logic       txShiftOut,
  output logic       serialOut,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irq
);

  rxStrobe_t  rxStb;
  rxCfg_t     rxCfg;
  logic [3:0] lineStat;
  logic       dataAvail;

  uart_rx_ctrl #(.OSR(OSR)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .serialIn   (serialIn),
    .txShiftOut (txShiftOut),
    .loopback   (rxCfg.loopback),
    .parityEn   (rxCfg.parityEn),
    .parityOdd  (rxCfg.parityOdd),
    .stb        (rxStb)
  );

  uart_rx_datapath #(.DEPTH(DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (rxStb),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cfg       (rxCfg),
    .lineStat  (lineStat),
    .dataAvail (dataAvail)
  );

  assign serialOut = rxCfg.loopback ? 1'b1 : txShiftOut;
  assign irq = (rxCfg.rxIrqEn & dataAvail) | (rxCfg.lsIrqEn & (|lineStat[3:1]));

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk
  import uart_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       loopback,
  input logic       parityEn,
  input logic       lsIrqEn,
  input rxStrobe_t  stb,
  input logic [3:0] lineStat,
  input logic       irq,
  input logic       serialOut,
  input logic [1:0] regAddr,
  input logic       regRdEn
);

  logic lsrRead;
  assign lsrRead = regRdEn && regAddr == ADDR_STAT;

  // R2
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.charDone && !parityEn |-> !stb.parityErr);

  // R5
  empty_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStat[0] |-> lineStat[3:2] == 2'b00);

  // R6
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    lsrRead && !stb.charDone |=> lineStat[3:1] == 3'b000);

  // R8
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStat[1] && !lsrRead |=> lineStat[1]);

  // R8
  err_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    lsIrqEn && lineStat[1] |-> irq);

  // R11
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopback |-> serialOut);

endmodule

bind uart_rx_status uart_rx_status_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loopback  (rxCfg.loopback),
  .parityEn  (rxCfg.parityEn),
  .lsIrqEn   (rxCfg.lsIrqEn),
  .stb       (rxStb),
  .lineStat  (lineStat),
  .irq       (irq),
  .serialOut (serialOut),
  .regAddr   (regAddr),
  .regRdEn   (regRdEn)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;

  localparam int BIT = 16;
  localparam int NVEC = 8;
  // {data[11:4], parityEn[3], odd[2], badParity[1], badStop[0]}
  localparam logic [11:0] VEC [NVEC] = '{
    12'h550, 12'hA38, 12'hA3A, 12'h3CC, 12'h3CE, 12'h001, 12'h81F, 12'hFF8
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       txLine = 1'b1;
  logic       serialOut, irq;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rstN(rstN), .sampleTick(1'b1), .serialIn(rxLine),
    .txShiftOut(txLine), .serialOut(serialOut), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic driveBit(input logic b, input bit toTx);
    if (toTx) txLine = b; else rxLine = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit parEn, input bit odd,
                           input bit badPar, input bit badStop, input bit toTx);
    logic p;
    @(negedge clk);
    p = (odd ? ~^d : ^d) ^ badPar;
    driveBit(1'b0, toTx);
    for (int i = 0; i < 8; i++) driveBit(d[i], toTx);
    if (parEn) driveBit(p, toTx);
    driveBit(!badStop, toTx);
    if (badStop) repeat (10) driveBit(1'b1, toTx);
    repeat (3) driveBit(1'b1, toTx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd, d;
    logic pEn, odd, bPar, bStop, expPe;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    regRead(2'd2, rd); check("R12 status", rd, 8'h00);
    regRead(2'd1, rd); check("R12 control", rd, 8'h00);
    check("R12 irq", {7'b0, irq}, 8'h00);
    check("R11 serialOut follows tx", {7'b0, serialOut}, 8'h01);

    // R1 short low pulse rejected
    @(negedge clk); rxLine = 1'b0;
    repeat (4) @(negedge clk); rxLine = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    regRead(2'd2, rd); check("R1 glitch ignored", rd, 8'h00);

    // table walk: R1 R2 R3 R4 R5 in queue mode, threshold 1
    for (int i = 0; i < NVEC; i++) begin
      d = VEC[i][11:4]; pEn = VEC[i][3]; odd = VEC[i][2];
      bPar = VEC[i][1]; bStop = VEC[i][0];
      expPe = pEn & bPar;
      regWrite(2'd1, {3'b000, odd, pEn, 2'b00, 1'b1});
      sendFrame(d, pEn, odd, bPar, bStop, 1'b0);
      regRead(2'd2, rd);
      check("R2 R3 R5 head marks", rd, {4'b0, bStop, expPe, 1'b0, 1'b1});
      regRead(2'd0, rd); check("R1 data", rd, d);
      if (bStop) begin
        regRead(2'd2, rd); check("R4 resync char marks", rd, 8'h01);
        regRead(2'd0, rd); check("R4 resync char data", rd, 8'hFF);
      end
      regRead(2'd2, rd); check("R6 empty after pop", rd, 8'h00);
    end

    // R5 marks follow head across pops, R6 read clears marks
    regWrite(2'd1, 8'h09);
    sendFrame(8'h12, 1, 0, 0, 0, 0);
    sendFrame(8'h34, 1, 0, 1, 0, 0);
    regRead(2'd2, rd); check("R5 clean head", rd, 8'h01);
    regRead(2'd0, rd); check("R5 first data", rd, 8'h12);
    regRead(2'd2, rd); check("R5 new head marked", rd, 8'h05);
    regRead(2'd2, rd); check("R6 marks cleared, ready kept", rd, 8'h01);
    regRead(2'd0, rd); check("R5 second data", rd, 8'h34);

    // R9 and R10 single holding register
    regWrite(2'd1, 8'h40);
    sendFrame(8'h11, 0, 0, 0, 0, 0);
    check("R10 irq at one char, queue off", {7'b0, irq}, 8'h01);
    sendFrame(8'h22, 0, 0, 0, 0, 0);
    regRead(2'd2, rd); check("R9 overrun", rd, 8'h03);
    regRead(2'd0, rd); check("R9 first kept", rd, 8'h11);
    regRead(2'd2, rd); check("R9 second dropped", rd, 8'h00);

    // R10 threshold 4 then 1
    regWrite(2'd1, 8'h43);
    for (int k = 0; k < 3; k++) sendFrame(8'(8'h30 + k), 0, 0, 0, 0, 0);
    check("R10 below 4", {7'b0, irq}, 8'h00);
    sendFrame(8'h33, 0, 0, 0, 0, 0);
    check("R10 at 4", {7'b0, irq}, 8'h01);
    regRead(2'd0, rd); check("R10 pop data", rd, 8'h30);
    check("R10 back below 4", {7'b0, irq}, 8'h00);
    regWrite(2'd1, 8'h41);
    check("R10 threshold 1", {7'b0, irq}, 8'h01);
    for (int k = 1; k < 4; k++) begin
      regRead(2'd0, rd); check("R10 drain", rd, 8'(8'h30 + k));
    end

    // R7 R8 full queue overrun
    regWrite(2'd1, 8'h87);
    for (int k = 0; k < 16; k++) sendFrame(8'(k * 7 + 1), 0, 0, 0, 0, 0);
    check("R8 no irq when full", {7'b0, irq}, 8'h00);
    sendFrame(8'hEE, 0, 0, 0, 0, 0);
    check("R8 irq on overrun", {7'b0, irq}, 8'h01);
    for (int k = 0; k < 16; k++) begin
      regRead(2'd0, rd); check("R7 contents intact", rd, 8'(k * 7 + 1));
    end
    check("R8 irq held past data reads", {7'b0, irq}, 8'h01);
    regRead(2'd2, rd); check("R7 overrun, extra dropped", rd, 8'h02);
    check("R8 irq clear after status read", {7'b0, irq}, 8'h00);
    regRead(2'd2, rd); check("R6 overrun cleared", rd, 8'h00);

    // R11 loopback
    regWrite(2'd1, 8'h21);
    @(negedge clk); txLine = 1'b0;
    @(negedge clk);
    check("R11 serialOut high in loopback", {7'b0, serialOut}, 8'h01);
    txLine = 1'b1;
    rxLine = 1'b0;
    repeat (BIT) @(negedge clk);
    sendFrame(8'h5A, 0, 0, 0, 0, 1);
    regRead(2'd0, rd); check("R11 loopback data", rd, 8'h5A);
    regRead(2'd2, rd); check("R11 serialIn ignored", rd, 8'h00);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    regWrite(2'd1, 8'h01);
    txLine = 1'b0;
    @(negedge clk);
    check("R11 serialOut follows tx", {7'b0, serialOut}, 8'h00);
    txLine = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule